// File: doc/BRIEF.md
# Signed Multiply-Accumulate Coprocessor with Sticky Overflow

This block is a coprocessor with a 16-bit data path. It multiplies two signed 16-bit arguments and adds the product into a 32-bit accumulator. The CPU first loads an 8-bit mode register. It then issues operation accesses, each carrying two arguments. Every access returns one 16-bit data word and four condition flags. Two 32-bit result registers hold the state. Result register 0 is the accumulator. Result register 1 keeps the most recent product that was committed.

In signed MAC mode the block checks the 32-bit sum for signed overflow. When it finds one, it sets a sticky V flag, and while V is set both result registers are frozen. A separate group of read modes returns either 16-bit half of either result register. A read never modifies any state, and all of its flags come back as zero. Any other mode value is an idle access, whose only effect is to clear V.

Operation accesses use a valid/ready handshake. An access is taken when `op_valid` and `op_ready` are both high on a clock edge. Its response is registered and appears on the next cycle with `rsp_valid` high. The response stays constant until the cycle in which `rsp_ready` is high. `op_ready` is low only while a response is pending and `rsp_ready` is low. A new access can therefore be taken in the same cycle that the previous response drains.

Top module: `mac_copro`

## Requirements
- R1: A synchronous active-high `rst` clears both result registers, V and the mode register, and drives `rsp_valid` low. Out of reset `op_ready` is high, and mode 0x00 is an idle mode.
- R2: An access is taken on a clock edge where `op_valid` and `op_ready` are both high. Its response appears in the next cycle. `op_ready` equals NOT `rsp_valid` OR `rsp_ready`. While `rsp_valid` is high and `rsp_ready` is low, `rsp_data` and `rsp_flags` hold their values.
- R3: Mode 0x07 is signed MAC. With V clear and no overflow, result register 0 takes (reg0 + a*b) mod 2^32, where a*b is the full signed 32-bit product. Result register 1 takes the product. The response data is bits [15:0] of the new register 0.
- R4: In mode 0x07 the flags are computed from the sum reg0 + a*b: C is the carry out of the unsigned 32-bit addition, Z is set when the sum is zero, N is sum bit 31, and V is the new V value. The flag layout is `rsp_flags[3]`=C, `[2]`=V, `[1]`=Z, `[0]`=N.
- R5: Overflow occurs when the product and register 0 are both non-negative and the sum is negative, or when both are negative and the sum is non-negative. An overflow sets V, leaves both result registers unchanged, and returns bits [15:0] of the held register 0.
- R6: While V is set, a mode 0x07 access writes neither result register. It computes overflow again from the held register 0 plus the new product. V stays set if that overflows and is cleared if it does not. The response data is the held register 0 bits [15:0].
- R7: The read modes are 0x03 (reg0[15:0]), 0x13 (reg0[31:16]), 0x23 (reg1[15:0]) and 0x33 (reg1[31:16]). Mode bit 5 picks the register and bit 4 picks the half. A read returns flags 0000 and changes neither result register nor V.
- R8: An access in any mode that is neither MAC nor read clears V. It returns data 0 and flags 0000 and leaves both result registers unchanged.
- R9: A write to the mode register (`mode_we`) takes effect for accesses taken on later edges. An access taken on the same edge as a mode write uses the previous mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| mode_we | input | 1 | Write enable for the mode register |
| mode_wdata | input | 8 | New mode value |
| op_valid | input | 1 | Operation access request |
| op_ready | output | 1 | Access can be taken this cycle |
| op_arg_a | input | 16 | First signed argument |
| op_arg_b | input | 16 | Second signed argument |
| rsp_valid | output | 1 | Response available |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_data | output | 16 | Returned 16-bit data |
| rsp_flags | output | 4 | {C, V, Z, N} |

## Verification
The bench accumulates large positive products until the sum crosses into negative, and large negative products until it crosses back to positive. A design that compares the wrong sign bits, or that writes the wrapped sum, would then return a different low half or fail to raise V. It then sends a MAC access that does not overflow while V is set. A design that resumes accumulating on that same access shows the next low half one access too early. It also tests an idle-mode clear followed by MAC, a response held under back-pressure while the mode changes, and a mode write on the same edge as an access. These expose V staying set, a response that drifts or is overwritten, and a mode applied one cycle early.

// File: rtl/mac_pkg.sv
package mac_pkg;
  localparam int MODE_W = 8;
  localparam logic [MODE_W-1:0] MODE_SMAC = 8'h07;

  typedef enum logic [1:0] {
    KIND_IDLE = 2'd0,
    KIND_SMAC = 2'd1,
    KIND_READ = 2'd2
  } acc_kind_e;

  typedef struct packed {
    logic c;
    logic v;
    logic z;
    logic n;
  } cond_flags_t;
endpackage

// File: rtl/mac_mode_decode.sv
module mac_mode_decode
  import mac_pkg::*;
(
  input  logic [MODE_W-1:0] mode,
  output acc_kind_e         kind,
  output logic [1:0]        half_idx
);
  // read group: upper two bits zero, low nibble 3; bits [5:4] pick register and half
  always_comb begin
    if (mode == MODE_SMAC)
      kind = KIND_SMAC;
    else if (mode[7:6] == 2'b00 && mode[3:0] == 4'h3)
      kind = KIND_READ;
    else
      kind = KIND_IDLE;
  end
  assign half_idx = mode[5:4];
endmodule

// File: rtl/mac_sum_unit.sv
module mac_sum_unit #(
  parameter int DW = 16,
  localparam int RW = 2 * DW
) (
  input  logic [DW-1:0] arg_a,
  input  logic [DW-1:0] arg_b,
  input  logic [RW-1:0] acc,
  output logic [RW-1:0] prod,
  output logic [RW-1:0] sum,
  output logic          carry,
  output logic          ovf
);
  logic signed [RW-1:0] a_ext, b_ext;
  logic [RW:0] wide;

  assign a_ext = {{DW{arg_a[DW-1]}}, arg_a};
  assign b_ext = {{DW{arg_b[DW-1]}}, arg_b};
  assign prod  = a_ext * b_ext;
  assign wide  = {1'b0, acc} + {1'b0, prod};
  assign sum   = wide[RW-1:0];
  assign carry = wide[RW];
  // like-signed addends giving a result of the other sign
  assign ovf   = (prod[RW-1] == acc[RW-1]) && (sum[RW-1] != acc[RW-1]);
endmodule

// File: rtl/mac_half_mux.sv
module mac_half_mux #(
  parameter int DW   = 16,
  parameter int NREG = 2,
  localparam int RW   = 2 * DW,
  localparam int NH   = 2 * NREG,
  localparam int SELW = $clog2(NH)
) (
  input  logic [NREG-1:0][RW-1:0] regs,
  input  logic [SELW-1:0]         sel,
  output logic [DW-1:0]           dout
);
  logic [DW-1:0] halves [NH];

  for (genvar i = 0; i < NH; i++) begin : g_half
    assign halves[i] = regs[i/2][(i%2)*DW +: DW];
  end

  assign dout = halves[sel];
endmodule

// File: rtl/mac_copro.sv
module mac_copro
  import mac_pkg::*;
#(
  parameter int DW = 16,
  localparam int RW   = 2 * DW,
  localparam int NREG = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mode_we,
  input  logic [MODE_W-1:0] mode_wdata,
  input  logic              op_valid,
  output logic              op_ready,
  input  logic [DW-1:0]     op_arg_a,
  input  logic [DW-1:0]     op_arg_b,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DW-1:0]     rsp_data,
  output logic [3:0]        rsp_flags
);
  logic [MODE_W-1:0] mode_q;
  logic [RW-1:0]     res0_q, res1_q;
  logic              v_q;
  logic              rsp_valid_q;
  logic [DW-1:0]     rsp_data_q;
  cond_flags_t       flags_q;

  acc_kind_e kind;
  logic [1:0] half_idx;
  logic [RW-1:0] prod, sum;
  logic carry, ovf;
  logic [DW-1:0] read_word;
  logic accept, acc_we;
  logic [NREG-1:0][RW-1:0] reg_bank;

  mac_mode_decode u_dec (
    .mode     (mode_q),
    .kind     (kind),
    .half_idx (half_idx)
  );

  mac_sum_unit #(.DW(DW)) u_sum (
    .arg_a (op_arg_a),
    .arg_b (op_arg_b),
    .acc   (res0_q),
    .prod  (prod),
    .sum   (sum),
    .carry (carry),
    .ovf   (ovf)
  );

  assign reg_bank = {res1_q, res0_q};

  mac_half_mux #(.DW(DW), .NREG(NREG)) u_mux (
    .regs (reg_bank),
    .sel  (half_idx),
    .dout (read_word)
  );

  assign op_ready = !rsp_valid_q || rsp_ready;
  assign accept   = op_valid && op_ready;
  assign acc_we   = accept && (kind == KIND_SMAC) && !v_q && !ovf;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= '0;
    end else if (mode_we) begin
      mode_q <= mode_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res0_q <= '0;
      res1_q <= '0;
    end else if (acc_we) begin
      res0_q <= sum;
      res1_q <= prod;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      v_q <= 1'b0;
    end else if (accept) begin
      case (kind)
        KIND_SMAC: v_q <= ovf;
        KIND_READ: v_q <= v_q;
        default:   v_q <= 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid_q <= 1'b0;
      rsp_data_q  <= '0;
      flags_q     <= '0;
    end else if (accept) begin
      rsp_valid_q <= 1'b1;
      case (kind)
        KIND_SMAC: begin
          rsp_data_q <= acc_we ? sum[DW-1:0] : res0_q[DW-1:0];
          flags_q    <= '{c: carry, v: ovf, z: (sum == '0), n: sum[RW-1]};
        end
        KIND_READ: begin
          rsp_data_q <= read_word;
          flags_q    <= '0;
        end
        default: begin
          rsp_data_q <= '0;
          flags_q    <= '0;
        end
      endcase
    end else if (rsp_ready) begin
      rsp_valid_q <= 1'b0;
    end
  end

  assign rsp_valid = rsp_valid_q;
  assign rsp_data  = rsp_data_q;
  assign rsp_flags = flags_q;
endmodule

// File: rtl/mac_copro_chk.sv
module mac_copro_chk #(
  parameter int DW = 16,
  localparam int RW = 2 * DW
) (
  input logic          clk,
  input logic          rst,
  input logic          op_valid,
  input logic          op_ready,
  input logic          rsp_valid,
  input logic          rsp_ready,
  input logic [DW-1:0] rsp_data,
  input logic [3:0]    rsp_flags,
  input logic [7:0]    mode_q,
  input logic          v_q,
  input logic [RW-1:0] res0_q,
  input logic [RW-1:0] res1_q
);
  logic take, in_read, in_mac;
  assign take    = op_valid && op_ready;
  assign in_read = (mode_q[7:6] == 2'b00) && (mode_q[3:0] == 4'h3);
  assign in_mac  = (mode_q == 8'h07);

  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> !rsp_valid && !v_q && res0_q == '0 && res1_q == '0 && mode_q == '0);

  // R2
  rsp_hold_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_data) && $stable(rsp_flags));

  // R5
  overflow_hold_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(v_q) |-> $stable(res0_q) && $stable(res1_q));

  // R6
  frozen_chk: assert property (@(posedge clk) disable iff (rst)
    take && in_mac && v_q |=> $stable(res0_q) && $stable(res1_q));

  // R7
  read_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    take && in_read |=> rsp_flags == 4'h0 && $stable(res0_q) && $stable(res1_q) && $stable(v_q));

  // R8
  idle_clear_chk: assert property (@(posedge clk) disable iff (rst)
    take && !in_read && !in_mac |=> !v_q && $stable(res0_q) && rsp_data == '0);
endmodule

bind mac_copro mac_copro_chk #(.DW(DW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .op_valid  (op_valid),
  .op_ready  (op_ready),
  .rsp_valid (rsp_valid),
  .rsp_ready (rsp_ready),
  .rsp_data  (rsp_data),
  .rsp_flags (rsp_flags),
  .mode_q    (mode_q),
  .v_q       (v_q),
  .res0_q    (res0_q),
  .res1_q    (res1_q)
);

// File: tb/mac_copro_tb.sv
module mac_copro_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic mode_we = 1'b0;
  logic [7:0] mode_wdata = '0;
  logic op_valid = 1'b0;
  logic op_ready;
  logic [15:0] op_arg_a = '0, op_arg_b = '0;
  logic rsp_valid;
  logic rsp_ready = 1'b1;
  logic [15:0] rsp_data;
  logic [3:0] rsp_flags;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  mac_copro u_dut (
    .clk(clk), .rst(rst), .mode_we(mode_we), .mode_wdata(mode_wdata),
    .op_valid(op_valid), .op_ready(op_ready), .op_arg_a(op_arg_a), .op_arg_b(op_arg_b),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data), .rsp_flags(rsp_flags)
  );

  // {mode, a, b, expected data, expected flags C V Z N}
  localparam logic [59:0] VEC [25] = '{
    {8'h07, 16'h0003, 16'h0004, 16'h000C, 4'h0},
    {8'h07, 16'hFFFE, 16'h0005, 16'h0002, 4'h8},
    {8'h13, 16'h0000, 16'h0000, 16'h0000, 4'h0},
    {8'h23, 16'h0000, 16'h0000, 16'hFFF6, 4'h0},
    {8'h33, 16'h0000, 16'h0000, 16'hFFFF, 4'h0},
    {8'h07, 16'hFFFE, 16'h0001, 16'h0000, 4'hA},
    {8'h07, 16'h7FFF, 16'h7FFF, 16'h0001, 4'h0},
    {8'h07, 16'h7FFF, 16'h7FFF, 16'h0002, 4'h0},
    {8'h07, 16'h7FFF, 16'h7FFF, 16'h0002, 4'h5},
    {8'h13, 16'h0000, 16'h0000, 16'h7FFE, 4'h0},
    {8'h07, 16'h0001, 16'h0001, 16'h0002, 4'h0},
    {8'h07, 16'h0001, 16'h0001, 16'h0003, 4'h0},
    {8'h23, 16'h0000, 16'h0000, 16'h0001, 4'h0},
    {8'h07, 16'h7FFF, 16'h7FFF, 16'h0003, 4'h5},
    {8'h07, 16'h7FFF, 16'h7FFF, 16'h0003, 4'h5},
    {8'h00, 16'h1234, 16'h5678, 16'h0000, 4'h0},
    {8'h03, 16'h0000, 16'h0000, 16'h0003, 4'h0},
    {8'h07, 16'h0001, 16'h0001, 16'h0004, 4'h0},
    {8'h07, 16'h8000, 16'h7FFF, 16'h8004, 4'h8},
    {8'h07, 16'h8000, 16'h7FFF, 16'h0004, 4'h1},
    {8'h07, 16'h8000, 16'h7FFF, 16'h8004, 4'h9},
    {8'h07, 16'h8000, 16'h7FFF, 16'h0004, 4'h9},
    {8'h07, 16'h8000, 16'h7FFF, 16'h0004, 4'hC},
    {8'h13, 16'h0000, 16'h0000, 16'h8000, 4'h0},
    {8'h33, 16'h0000, 16'h0000, 16'hC000, 4'h0}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic set_mode(input logic [7:0] m);
    @(negedge clk);
    mode_we = 1'b1; mode_wdata = m;
    @(negedge clk);
    mode_we = 1'b0;
  endtask

  // one access with the response drained right away
  task automatic run_op(input string tag, input logic [7:0] m, input logic [15:0] a,
                        input logic [15:0] b, input logic [15:0] ed, input logic [3:0] ef);
    set_mode(m);
    op_valid = 1'b1; op_arg_a = a; op_arg_b = b; rsp_ready = 1'b1;
    @(negedge clk);
    op_valid = 1'b0;
    check(tag, {11'd0, rsp_valid, rsp_data, rsp_flags}, {11'd0, 1'b1, ed, ef});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: idle outputs after reset, registers clear
    check("R1 reset handshake", {30'd0, rsp_valid, op_ready}, {30'd0, 1'b0, 1'b1});
    run_op("R1 reg0 low after reset", 8'h03, 16'h0, 16'h0, 16'h0000, 4'h0);
    run_op("R1 reg1 high after reset", 8'h33, 16'h0, 16'h0, 16'h0000, 4'h0);

    // table walk: R3 R4 R5 R6 R7 R8
    for (int i = 0; i < 25; i++) begin
      logic [59:0] v;
      v = VEC[i];
      run_op($sformatf("R3/R4/R5/R6/R7/R8 vector %0d", i), v[59:52], v[51:36], v[35:20], v[19:4], v[3:0]);
    end

    // R2: back-pressure holds response, blocks new access, mode changes meanwhile
    set_mode(8'h03);
    rsp_ready = 1'b0;
    op_valid = 1'b1;
    @(negedge clk);
    check("R2 first response under stall", {15'd0, rsp_valid, rsp_data}, {15'd0, 1'b1, 16'h0004});
    check("R2 op_ready low under stall", {31'd0, op_ready}, 32'd0);
    mode_we = 1'b1; mode_wdata = 8'h13;
    @(negedge clk);
    mode_we = 1'b0;
    @(negedge clk);
    check("R2 response held", {15'd0, rsp_valid, rsp_data}, {15'd0, 1'b1, 16'h0004});
    rsp_ready = 1'b1;
    @(negedge clk);
    op_valid = 1'b0;
    check("R2 drain and accept same edge", {15'd0, rsp_valid, rsp_data}, {15'd0, 1'b1, 16'h8000});
    @(negedge clk);
    check("R2 response gone after drain", {31'd0, rsp_valid}, 32'd0);

    // R9: mode write on the same edge as an access uses the old mode
    set_mode(8'h03);
    mode_we = 1'b1; mode_wdata = 8'h13; op_valid = 1'b1;
    @(negedge clk);
    mode_we = 1'b0; op_valid = 1'b0;
    check("R9 same-edge uses old mode", {16'd0, rsp_data}, {16'd0, 16'h0004});
    op_valid = 1'b1;
    @(negedge clk);
    op_valid = 1'b0;
    check("R9 later access uses new mode", {16'd0, rsp_data}, {16'd0, 16'h8000});

    // R1: reset in mid-run clears V and both registers
    run_op("R5 overflow before reset", 8'h07, 16'h8000, 16'h7FFF, 16'h0004, 4'hC);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    check("R1 mid-run reset handshake", {30'd0, rsp_valid, op_ready}, {30'd0, 1'b0, 1'b1});
    run_op("R1 reg0 high cleared", 8'h13, 16'h0, 16'h0, 16'h0000, 4'h0);
    run_op("R1 V cleared, MAC resumes", 8'h07, 16'h0001, 16'h0001, 16'h0001, 4'h0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule